// File: doc/BRIEF.md
# Accumulator Multi-Cycle Processor

A small multi-cycle processor with 24-bit words built from three bytes. It holds five architectural registers: accumulator A, index X, linkage L, program counter PC and status word SW. It fetches a three-byte instruction over a byte-wide synchronous memory port. It then forms a target address, either direct or indexed, and carries out a load, a store, an add or subtract, a compare, a jump, a call or a return. Memory is byte addressed with a 15-bit address, so it spans 32768 bytes.

The memory port is single ported. The address and write enable are driven from the current state. Read data returns in the cycle after the address is presented. A 24-bit word occupies three consecutive bytes and is addressed by its lowest byte, which holds the most significant byte. An opcode that is not defined stops the machine and raises `halt`, which stays high until reset.

Top module: `acc_cpu`

## Requirements
- R1: While reset is held and after it is released, `halt` is low and `mem_we` is low, and the first byte fetched is at address 0 (PC resets to 0, all registers reset to 0).
- R2: An instruction is three bytes: an opcode byte, then a byte whose top bit is the index flag, with the 15-bit address field below it. After each fetch the PC advances by 3. Opcodes (hex): LOADA 00, LOADX 04, LOADL 08, STOREA 0C, STOREX 10, STOREL 14, ADD 18, SUB 1C, CMP 20, JMP 24, JLT 28, JEQ 2C, JGT 30, CALL 34, RET 38.
- R3: A load reads the word at the target address, most significant byte first, into A, X or L.
- R4: A store writes the selected register as exactly three consecutive byte writes to the target address and the two addresses above it, most significant byte first.
- R5: With the index flag clear, the target address is the address field. With the flag set, it is the address field plus X, taken modulo 2^15.
- R6: ADD and SUB combine A with the memory word modulo 2^24 and write the result to A.
- R7: CMP compares A with the memory word as signed 24-bit values. It writes the condition code into SW[1:0] (equal 00, less 01, greater 10) and leaves A unchanged.
- R8: JLT, JEQ and JGT load the target address into PC only when the condition code matches. JMP always loads it.
- R9: CALL writes the address of the following instruction into L and jumps to the target address. RET jumps to the address held in L.
- R10: An undefined opcode, including any with nonzero low two bits, raises `halt`. From then on the machine makes no memory write and PC no longer changes, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 15 | Byte address to memory |
| mem_we | output | 1 | Byte write enable |
| mem_wdata | output | 8 | Byte write data |
| mem_rdata | input | 8 | Read data, valid one cycle after its address |
| halt | output | 1 | High after an undefined opcode |

## Verification
The compare runs with operands whose signed order differs from their unsigned order. A design that compared unsigned would then take the wrong branch and run into an undefined opcode, so expected stores go missing. Sums that overflow 24 bits and differences that go negative show up in the stored bytes, whose expected order is fixed most significant byte first. Indexed accesses cover both a plain offset and an address that wraps past 2^15; a design that dropped the index or failed to wrap would read a zero word. A return that does not come back to the instruction after the call would store the wrong linkage value or hit an undefined opcode. Writes that appear after `halt` are reported as unexpected.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  typedef enum logic [1:0] {
    CC_EQ = 2'b00,
    CC_LT = 2'b01,
    CC_GT = 2'b10
  } cc_t;

  typedef enum logic [2:0] {
    K_LOAD, K_STORE, K_ARITH, K_CMP, K_JUMP, K_CALL, K_RET, K_BAD
  } kind_t;

  typedef enum logic [1:0] { R_A, R_X, R_L } rsel_t;

  typedef enum logic [1:0] { C_ALL, C_LT, C_EQ, C_GT } cond_t;

  typedef struct packed {
    kind_t kind;
    rsel_t rsel;
    logic  sub;
    cond_t cond;
  } ctrl_t;

  typedef enum logic [2:0] {
    S_FETCH, S_EXEC, S_READ, S_WRITE, S_HALT
  } state_t;

  localparam logic [7:0] OP_LOADA  = 8'h00;
  localparam logic [7:0] OP_LOADX  = 8'h04;
  localparam logic [7:0] OP_LOADL  = 8'h08;
  localparam logic [7:0] OP_STOREA = 8'h0C;
  localparam logic [7:0] OP_STOREX = 8'h10;
  localparam logic [7:0] OP_STOREL = 8'h14;
  localparam logic [7:0] OP_ADD    = 8'h18;
  localparam logic [7:0] OP_SUB    = 8'h1C;
  localparam logic [7:0] OP_CMP    = 8'h20;
  localparam logic [7:0] OP_JMP    = 8'h24;
  localparam logic [7:0] OP_JLT    = 8'h28;
  localparam logic [7:0] OP_JEQ    = 8'h2C;
  localparam logic [7:0] OP_JGT    = 8'h30;
  localparam logic [7:0] OP_CALL   = 8'h34;
  localparam logic [7:0] OP_RET    = 8'h38;

endpackage

// File: rtl/acc_cpu_decode.sv
module acc_cpu_decode
  import acc_cpu_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic [OP_W-1:0] opcode,
  output ctrl_t           ctrl
);

  always_comb begin
    ctrl = '{kind: K_BAD, rsel: R_A, sub: 1'b0, cond: C_ALL};
    unique case (opcode)
      OP_LOADA:  ctrl = '{kind: K_LOAD,  rsel: R_A, sub: 1'b0, cond: C_ALL};
      OP_LOADX:  ctrl = '{kind: K_LOAD,  rsel: R_X, sub: 1'b0, cond: C_ALL};
      OP_LOADL:  ctrl = '{kind: K_LOAD,  rsel: R_L, sub: 1'b0, cond: C_ALL};
      OP_STOREA: ctrl = '{kind: K_STORE, rsel: R_A, sub: 1'b0, cond: C_ALL};
      OP_STOREX: ctrl = '{kind: K_STORE, rsel: R_X, sub: 1'b0, cond: C_ALL};
      OP_STOREL: ctrl = '{kind: K_STORE, rsel: R_L, sub: 1'b0, cond: C_ALL};
      OP_ADD:    ctrl = '{kind: K_ARITH, rsel: R_A, sub: 1'b0, cond: C_ALL};
      OP_SUB:    ctrl = '{kind: K_ARITH, rsel: R_A, sub: 1'b1, cond: C_ALL};
      OP_CMP:    ctrl = '{kind: K_CMP,   rsel: R_A, sub: 1'b1, cond: C_ALL};
      OP_JMP:    ctrl = '{kind: K_JUMP,  rsel: R_A, sub: 1'b0, cond: C_ALL};
      OP_JLT:    ctrl = '{kind: K_JUMP,  rsel: R_A, sub: 1'b0, cond: C_LT};
      OP_JEQ:    ctrl = '{kind: K_JUMP,  rsel: R_A, sub: 1'b0, cond: C_EQ};
      OP_JGT:    ctrl = '{kind: K_JUMP,  rsel: R_A, sub: 1'b0, cond: C_GT};
      OP_CALL:   ctrl = '{kind: K_CALL,  rsel: R_L, sub: 1'b0, cond: C_ALL};
      OP_RET:    ctrl = '{kind: K_RET,   rsel: R_L, sub: 1'b0, cond: C_ALL};
      default:   ctrl = '{kind: K_BAD,   rsel: R_A, sub: 1'b0, cond: C_ALL};
    endcase
  end

endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  input  logic              sub,
  output logic [WORD_W-1:0] result,
  output cc_t               cc
);

  always_comb begin
    result = sub ? (a - b) : (a + b);
    if (a == b)                       cc = CC_EQ;
    else if ($signed(a) < $signed(b)) cc = CC_LT;
    else                              cc = CC_GT;
  end

endmodule

// File: rtl/acc_cpu_agen.sv
module acc_cpu_agen #(
  parameter int ADDR_W = 15,
  parameter int WORD_W = 24
) (
  input  logic [ADDR_W-1:0] field,
  input  logic              idx,
  input  logic [WORD_W-1:0] xreg,
  output logic [ADDR_W-1:0] ta
);

  always_comb begin
    ta = idx ? (field + xreg[ADDR_W-1:0]) : field;
  end

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter int BYTES  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              halt
);

  localparam int WORD_W = DATA_W * BYTES;
  localparam int CW     = $clog2(BYTES + 1);
  localparam int IDX_B  = WORD_W - DATA_W - 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  state_t            state_q, state_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [WORD_W-1:0] gath_q, gath_d;
  logic              gath_en;
  logic [WORD_W-1:0] ir_q, ir_d;
  logic              ir_en;
  logic [WORD_W-1:0] a_q, a_d, x_q, x_d, l_q, l_d, pc_q, pc_d, sw_q, sw_d;
  logic              a_en, x_en, l_en, pc_en, sw_en;

  logic [WORD_W-1:0] word_in;
  logic [WORD_W-1:0] alu_res;
  cc_t               alu_cc;
  ctrl_t             ctrl;
  logic [ADDR_W-1:0] ta;
  logic [WORD_W-1:0] store_src;
  logic              cond_ok;

  assign word_in = {gath_q[WORD_W-DATA_W-1:0], mem_rdata};

  acc_cpu_decode #(.OP_W(DATA_W)) u_dec (
    .opcode (ir_q[WORD_W-1 -: DATA_W]),
    .ctrl   (ctrl)
  );

  acc_cpu_agen #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_agen (
    .field (ir_q[ADDR_W-1:0]),
    .idx   (ir_q[IDX_B]),
    .xreg  (x_q),
    .ta    (ta)
  );

  acc_cpu_alu #(.WORD_W(WORD_W)) u_alu (
    .a      (a_q),
    .b      (word_in),
    .sub    (ctrl.sub),
    .result (alu_res),
    .cc     (alu_cc)
  );

  always_comb begin
    unique case (ctrl.rsel)
      R_X:     store_src = x_q;
      R_L:     store_src = l_q;
      default: store_src = a_q;
    endcase
  end

  always_comb begin
    unique case (ctrl.cond)
      C_LT:    cond_ok = (sw_q[1:0] == CC_LT);
      C_EQ:    cond_ok = (sw_q[1:0] == CC_EQ);
      C_GT:    cond_ok = (sw_q[1:0] == CC_GT);
      default: cond_ok = 1'b1;
    endcase
  end

  // memory port
  always_comb begin
    mem_we    = (state_q == S_WRITE);
    mem_wdata = '0;
    for (int i = 0; i < BYTES; i++) begin
      if (cnt_q == CW'(i)) mem_wdata = store_src[(BYTES-1-i)*DATA_W +: DATA_W];
    end
    unique case (state_q)
      S_FETCH:         mem_addr = pc_q[ADDR_W-1:0] + ADDR_W'(cnt_q);
      S_READ, S_WRITE: mem_addr = ta + ADDR_W'(cnt_q);
      default:         mem_addr = pc_q[ADDR_W-1:0];
    endcase
  end

  assign halt = (state_q == S_HALT);

  // next state
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    gath_d  = gath_q;  gath_en = 1'b0;
    ir_d    = word_in; ir_en   = 1'b0;
    a_d     = a_q;     a_en    = 1'b0;
    x_d     = x_q;     x_en    = 1'b0;
    l_d     = l_q;     l_en    = 1'b0;
    pc_d    = pc_q;    pc_en   = 1'b0;
    sw_d    = sw_q;    sw_en   = 1'b0;
    unique case (state_q)
      S_FETCH, S_READ: begin
        if (cnt_q == CW'(BYTES)) begin
          cnt_d = '0;
          if (state_q == S_FETCH) begin
            ir_en   = 1'b1;
            pc_en   = 1'b1;
            pc_d    = pc_q + WORD_W'(BYTES);
            state_d = S_EXEC;
          end else begin
            state_d = S_FETCH;
            unique case (ctrl.kind)
              K_LOAD: begin
                unique case (ctrl.rsel)
                  R_X:     begin x_en = 1'b1; x_d = word_in; end
                  R_L:     begin l_en = 1'b1; l_d = word_in; end
                  default: begin a_en = 1'b1; a_d = word_in; end
                endcase
              end
              K_ARITH: begin a_en = 1'b1; a_d = alu_res; end
              K_CMP:   begin sw_en = 1'b1; sw_d = {sw_q[WORD_W-1:2], alu_cc}; end
              default: ;
            endcase
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q != '0) begin
            gath_en = 1'b1;
            gath_d  = word_in;
          end
        end
      end
      S_EXEC: begin
        cnt_d   = '0;
        state_d = S_FETCH;
        unique case (ctrl.kind)
          K_LOAD, K_ARITH, K_CMP: state_d = S_READ;
          K_STORE: state_d = S_WRITE;
          K_JUMP: if (cond_ok) begin pc_en = 1'b1; pc_d = WORD_W'(ta); end
          K_CALL: begin
            l_en  = 1'b1; l_d  = pc_q;
            pc_en = 1'b1; pc_d = WORD_W'(ta);
          end
          K_RET:  begin pc_en = 1'b1; pc_d = l_q; end
          default: state_d = S_HALT;
        endcase
      end
      S_WRITE: begin
        if (cnt_q == CW'(BYTES - 1)) begin
          cnt_d   = '0;
          state_d = S_FETCH;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      S_HALT:  state_d = S_HALT;
      default: state_d = S_HALT;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q <= S_FETCH;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      gath_q <= '0;
      ir_q   <= '0;
    end else begin
      if (gath_en) gath_q <= gath_d;
      if (ir_en)   ir_q   <= ir_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      a_q  <= '0;
      x_q  <= '0;
      l_q  <= '0;
      pc_q <= '0;
      sw_q <= '0;
    end else begin
      if (a_en)  a_q  <= a_d;
      if (x_en)  x_q  <= x_d;
      if (l_en)  l_q  <= l_d;
      if (pc_en) pc_q <= pc_d;
      if (sw_en) sw_q <= sw_d;
    end
  end

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
  parameter int ADDR_W = 15,
  parameter int WORD_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              halt,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [WORD_W-1:0] pc
);

  // R10: no memory write once stopped
  a_r10_no_write_halted: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> !mem_we);

  // R10: the stop is permanent until reset
  a_r10_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> halt);

  // R10: program counter frozen while stopped
  a_r10_pc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && $past(halt)) |-> $stable(pc));

  // R4: store bytes go to consecutive addresses
  a_r4_write_seq: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + 1'b1));

  // R4: a store is exactly three byte writes
  a_r4_write_len: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we) && $past(mem_we, 2)) |=> !mem_we);

endmodule

bind acc_cpu acc_cpu_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .halt     (halt),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .pc       (pc_q)
);

// File: tb/acc_cpu_tb.sv
module acc_cpu_tb;

  logic        clk;
  logic        rst_n;
  logic [14:0] mem_addr;
  logic        mem_we;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;
  logic        halt;

  int total = 0;
  int bad   = 0;

  acc_cpu u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .halt      (halt)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // byte memory model, 4 KiB populated, zero above
  logic [7:0] mem [0:4095];
  always @(posedge clk) begin
    mem_rdata <= (mem_addr < 15'd4096) ? mem[mem_addr[11:0]] : 8'h00;
    if (mem_we && mem_addr < 15'd4096) mem[mem_addr[11:0]] <= mem_wdata;
  end

  // scoreboard queues
  logic [14:0] q_addr[$];
  logic [7:0]  q_data[$];
  string       q_tag[$];

  task automatic exp_word(input logic [14:0] a, input logic [23:0] v, input string tag);
    for (int i = 0; i < 3; i++) begin
      q_addr.push_back(a + 15'(i));
      q_data.push_back(v[23-8*i -: 8]);
      q_tag.push_back(tag);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      total++;
      if (q_addr.size() == 0) begin
        bad++;
        $display("FAIL R4/R10 unexpected write: actual addr=%h data=%h expected none", mem_addr, mem_wdata);
      end else begin
        logic [14:0] ea;
        logic [7:0]  ed;
        string       et;
        ea = q_addr.pop_front();
        ed = q_data.pop_front();
        et = q_tag.pop_front();
        if (mem_addr !== ea || mem_wdata !== ed) begin
          bad++;
          $display("FAIL %s write: actual addr=%h data=%h expected addr=%h data=%h",
                   et, mem_addr, mem_wdata, ea, ed);
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  int pcp = 0;
  task automatic ins(input logic [7:0] op, input bit x, input logic [14:0] a);
    mem[pcp]   = op;
    mem[pcp+1] = {x, a[14:8]};
    mem[pcp+2] = a[7:0];
    pcp += 3;
  endtask

  task automatic dword(input int a, input logic [23:0] v);
    mem[a] = v[23:16]; mem[a+1] = v[15:8]; mem[a+2] = v[7:0];
  endtask

  localparam logic [7:0] LOADA = 8'h00, LOADX = 8'h04, STOREA = 8'h0C, STOREX = 8'h10,
                         STOREL = 8'h14, ADD = 8'h18, SUB = 8'h1C, CMP = 8'h20,
                         JMP = 8'h24, JLT = 8'h28, JEQ = 8'h2C, JGT = 8'h30,
                         CALL = 8'h34, RET = 8'h38, UNDEF = 8'hFC, UNDEF_LOW = 8'h02;

  localparam logic [23:0] V0 = 24'h123456, V1 = 24'h7FFFFF, V2 = 24'h000001,
                          V3 = 24'hFFFFFE, V4 = 24'h000006, V5 = 24'h007C00,
                          VARR = 24'hABCDEF;

  initial begin
    int waited;
    logic [14:0] held_addr;
    rst_n = 1'b0;
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    dword(12'h800, V0); dword(12'h803, V1); dword(12'h806, V2);
    dword(12'h809, V3); dword(12'h80C, V4); dword(12'h820, V5);
    dword(12'h816, VARR);

    // program and expected stores
    ins(LOADA, 0, 15'h800); ins(STOREA, 0, 15'h900);
    exp_word(15'h900, V0, "R3");
    ins(ADD, 0, 15'h803);   ins(STOREA, 0, 15'h903);
    exp_word(15'h903, V0 + V1, "R6");
    ins(SUB, 0, 15'h809);   ins(STOREA, 0, 15'h906);
    exp_word(15'h906, V0 + V1 - V3, "R6");
    ins(LOADA, 0, 15'h806); ins(SUB, 0, 15'h803); ins(STOREA, 0, 15'h909);
    exp_word(15'h909, V2 - V1, "R6");
    ins(LOADA, 0, 15'h803); ins(ADD, 0, 15'h806); ins(STOREA, 0, 15'h90C);
    exp_word(15'h90C, V1 + V2, "R6");
    ins(LOADX, 0, 15'h80C); ins(LOADA, 1, 15'h810); ins(STOREA, 1, 15'h8F0);
    exp_word(15'h8F6, VARR, "R5");
    ins(STOREX, 0, 15'h912);
    exp_word(15'h912, V4, "R4");
    ins(LOADX, 0, 15'h820); ins(LOADA, 1, 15'h0C00); ins(STOREA, 0, 15'h915);
    exp_word(15'h915, V0, "R5");
    // signed compare: 1 vs -2 -> greater, A unchanged
    ins(LOADA, 0, 15'h806); ins(CMP, 0, 15'h809); ins(STOREA, 0, 15'h918);
    exp_word(15'h918, V2, "R7");
    ins(JLT, 0, 15'(pcp + 9)); ins(JEQ, 0, 15'(pcp + 6)); ins(JGT, 0, 15'(pcp + 6));
    ins(UNDEF, 0, 15'h0);
    // equal
    ins(LOADA, 0, 15'h803); ins(CMP, 0, 15'h803);
    ins(JLT, 0, 15'(pcp + 9)); ins(JGT, 0, 15'(pcp + 6)); ins(JEQ, 0, 15'(pcp + 6));
    ins(UNDEF, 0, 15'h0);
    // less
    ins(LOADA, 0, 15'h809); ins(CMP, 0, 15'h806);
    ins(JGT, 0, 15'(pcp + 9)); ins(JEQ, 0, 15'(pcp + 6)); ins(JLT, 0, 15'(pcp + 6));
    ins(UNDEF, 0, 15'h0);
    // R8: unconditional jump over an undefined opcode
    ins(JMP, 0, 15'(pcp + 6)); ins(UNDEF, 0, 15'h0);
    // R9: call and return
    ins(CALL, 0, 15'(pcp + 9));
    ins(STOREL, 0, 15'h921);
    ins(JMP, 0, 15'(pcp + 12));
    ins(STOREA, 0, 15'h91E);
    ins(RET, 0, 15'h0);
    ins(UNDEF, 0, 15'h0);
    ins(UNDEF_LOW, 0, 15'h0);
    exp_word(15'h91E, V3, "R9");
    exp_word(15'h921, 24'd123, "R9");

    // R1: reset state
    repeat (3) @(negedge clk);
    check(halt === 1'b0, "R1 halt in reset", 32'(halt), 0);
    check(mem_we === 1'b0, "R1 we in reset", 32'(mem_we), 0);
    check(mem_addr === 15'h0, "R1 first fetch addr", 32'(mem_addr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(halt === 1'b0 && mem_addr === 15'h0, "R1 after release", 32'(mem_addr), 0);

    // run until stop, watchdog bounded
    waited = 0;
    while (halt !== 1'b1 && waited < 20000) begin
      @(negedge clk);
      waited++;
    end
    check(halt === 1'b1, "R10 watchdog/halt reached", 32'(halt), 1);
    check(q_addr.size() == 0, "R2/R8 all expected stores seen", 32'(q_addr.size()), 0);

    // R10: stays stopped, no writes, address steady
    held_addr = mem_addr;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (i % 10 == 0) begin
        check(halt === 1'b1, "R10 halt sticky", 32'(halt), 1);
        check(mem_addr === held_addr, "R10 address held", 32'(mem_addr), 32'(held_addr));
      end
    end
    check(mem[12'h921] === 8'h00 && mem[12'h923] === 8'd123, "R9 linkage in memory",
          {mem[12'h921], mem[12'h922], mem[12'h923]}, 32'd123);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule